// File: doc/BRIEF.md
# USB Bit-Level Receive Front End

This block turns the two USB data wires, sampled by a single oversampling clock, into a stream of bit-level events for a byte-level receiver. Both wire inputs pass through a two-flop synchroniser. A phase tracker then recovers the bit clock. It samples each bit at its midpoint and restarts its phase on every line transition. One bit-rate sequencer handles the rest of the work: NRZI decoding, bit-stuff removal, stuff-error reporting, end-of-packet detection and resume detection.

The sampling clock runs at 4x the full-speed bit rate, which is 32x the low-speed bit rate, so one clock serves both speeds. `low_speed_i` selects the ratio and the idle (J) polarity. When `rx_en_i` is high, the first K seen on an idle bus starts a packet. When `rx_en_i` is low, a K held on the idle bus is timed as a possible resume.

Top module: `usb_rx_bit_frontend`

## Requirements
- R1: Each wire input passes through two flops before any logic uses it. At full speed, a K arriving on an idle bus with `rx_en_i` high produces the start code on the fifth rising clock edge after the input changes.
- R2: A bit lasts 4 clocks at full speed and 32 clocks at low speed. Line codes are {D+, D-}: 2'b10 is D+ high, 2'b01 is D- high, 2'b00 is SE0 and 2'b11 is SE1. J is 2'b10 at full speed and 2'b01 at low speed, and K is the other differential state.
- R3: Each bit is sampled once, at its midpoint. The sampling phase restarts on every line transition. Two samples are always at least three clocks apart, so no bit is sampled twice.
- R4: With `rx_en_i` high, a K sampled while idle emits code 8'h00 (start). The decoded bit 0 of that K follows on the next clock as code 8'h02.
- R5: Each decoded bit is emitted as code 8'h02 with its value on `strm_bit_o`. A sample equal to the previous differential level decodes to 1, and a change decodes to 0.
- R6: After six consecutive decoded 1s, a following 0 is dropped and not emitted.
- R7: A seventh consecutive 1 emits code 8'h03 in place of a bit, and the run count restarts.
- R8: Two consecutive single-ended samples (SE0 or SE1) inside a packet emit code 8'h01 (stop) and return the block to idle.
- R9: With `rx_en_i` low, a K held for 30 bit samples on an idle bus gives a one-clock `resume_o` pulse, and a K of 29 bits gives none. After a resume the block waits for a non-K sample before it returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock (4x full-speed bit rate) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 2 | Raw wire state {D+, D-} |
| low_speed_i | input | 1 | 1 selects low speed, 0 selects full speed |
| rx_en_i | input | 1 | 1 lets packets start, 0 lets an idle K be timed as a resume |
| strm_code_o | output | 8 | Stream code: 00 start, 01 stop, 02 data bit, 03 stuff error |
| strm_valid_o | output | 1 | One-clock strobe qualifying the code and the bit |
| strm_bit_o | output | 1 | Decoded bit, valid when the code is 02 |
| resume_o | output | 1 | One-clock resume-detected pulse |

## Verification
The assertions check on every cycle the properties that hold at all times:
- the two-flop delay of the synchronised line;
- the minimum spacing between bit samples;
- that only defined stream codes appear;
- that the stop and resume outputs are single-clock pulses that never coincide with a stream strobe.

Other behaviour can only be shown by the bench scenarios, which compare the whole emitted event sequence against one computed from the stimulus. These scenarios cover:
- NRZI decoding and stuff-bit removal;
- the stuff-error code and end-of-packet detection;
- phase tracking under bit-length jitter at both speeds;
- the exact 29-versus-30-bit boundary of resume detection.

// File: rtl/usb_rxfe_pkg.sv
package usb_rxfe_pkg;
  typedef enum logic [7:0] {
    CODE_START     = 8'h00,
    CODE_STOP      = 8'h01,
    CODE_BIT       = 8'h02,
    CODE_STUFF_ERR = 8'h03
  } strm_code_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_RES_WAIT,
    ST_RES_END
  } seq_state_e;

  localparam logic [1:0] LN_DP_HI = 2'b10;
  localparam logic [1:0] LN_DM_HI = 2'b01;
endpackage

// File: rtl/usb_rxfe_sync.sv
module usb_rxfe_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/usb_rxfe_clkrec.sv
module usb_rxfe_clkrec #(
  parameter int FS_OSR = 4,
  parameter int LS_OSR = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ln_i,
  input  logic       low_speed_i,
  output logic       tick_o
);
  localparam int CW = $clog2(LS_OSR + 1);

  logic [CW-1:0] cnt, last_ph, mid_ph;
  logic [1:0]    ln_q;
  logic          trans;

  assign last_ph = low_speed_i ? CW'(LS_OSR - 1) : CW'(FS_OSR - 1);
  assign mid_ph  = low_speed_i ? CW'(LS_OSR / 2) : CW'(FS_OSR / 2);
  assign trans   = (ln_i != ln_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ln_q <= '0;
      cnt  <= '0;
    end else begin
      ln_q <= ln_i;
      // a transition restarts the bit; the cycle it is seen counts as phase 0
      if (trans)                cnt <= CW'(1);
      else if (cnt >= last_ph)  cnt <= '0;
      else                      cnt <= cnt + CW'(1);
    end
  end

  // no sample on a transition cycle: one sample per bit interval
  assign tick_o = !trans && (cnt == mid_ph);
endmodule

// File: rtl/usb_rxfe_bitseq.sv
module usb_rxfe_bitseq
  import usb_rxfe_pkg::*;
#(
  parameter int STUFF_RUN   = 6,
  parameter int RESUME_BITS = 30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] ln_i,
  input  logic       low_speed_i,
  input  logic       rx_en_i,
  output logic       valid_o,
  output logic [7:0] code_o,
  output logic       bit_o,
  output logic       resume_o
);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int RW = $clog2(RESUME_BITS);

  seq_state_e    state;
  logic [1:0]    last_lvl, k_lvl;
  logic [OW-1:0] ones;
  logic [RW-1:0] rcnt;
  logic          se_seen, pend, se_now, dbit;

  assign k_lvl  = low_speed_i ? LN_DP_HI : LN_DM_HI;
  assign se_now = (ln_i[1] == ln_i[0]);
  assign dbit   = (ln_i == last_lvl);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      last_lvl <= '0;
      ones     <= '0;
      rcnt     <= '0;
      se_seen  <= 1'b0;
      pend     <= 1'b0;
      valid_o  <= 1'b0;
      code_o   <= CODE_START;
      bit_o    <= 1'b0;
      resume_o <= 1'b0;
    end else begin
      valid_o  <= 1'b0;
      resume_o <= 1'b0;
      if (pend) begin
        // bit 0 carried by the K that opened the packet
        valid_o <= 1'b1;
        code_o  <= CODE_BIT;
        bit_o   <= 1'b0;
        pend    <= 1'b0;
      end
      if (tick_i) begin
        unique case (state)
          ST_IDLE: if (ln_i == k_lvl) begin
            if (rx_en_i) begin
              valid_o  <= 1'b1;
              code_o   <= CODE_START;
              pend     <= 1'b1;
              last_lvl <= k_lvl;
              ones     <= '0;
              se_seen  <= 1'b0;
              state    <= ST_RECV;
            end else begin
              rcnt  <= RW'(1);
              state <= ST_RES_WAIT;
            end
          end
          ST_RECV: begin
            if (se_now) begin
              se_seen <= 1'b1;
              if (se_seen) begin
                valid_o <= 1'b1;
                code_o  <= CODE_STOP;
                se_seen <= 1'b0;
                state   <= ST_IDLE;
              end
            end else begin
              se_seen  <= 1'b0;
              last_lvl <= ln_i;
              if (ones == OW'(STUFF_RUN)) begin
                ones <= '0;
                if (dbit) begin
                  valid_o <= 1'b1;
                  code_o  <= CODE_STUFF_ERR;
                end
              end else begin
                valid_o <= 1'b1;
                code_o  <= CODE_BIT;
                bit_o   <= dbit;
                ones    <= dbit ? ones + OW'(1) : '0;
              end
            end
          end
          ST_RES_WAIT: begin
            if (ln_i != k_lvl) state <= ST_IDLE;
            else if (rcnt == RW'(RESUME_BITS - 1)) begin
              resume_o <= 1'b1;
              state    <= ST_RES_END;
            end else rcnt <= rcnt + RW'(1);
          end
          ST_RES_END: if (ln_i != k_lvl) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/usb_rx_bit_frontend.sv
module usb_rx_bit_frontend #(
  parameter int FS_OSR      = 4,
  parameter int LS_OSR      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int STUFF_RUN   = 6,
  parameter int RESUME_BITS = 30
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] line_i,
  input  logic       low_speed_i,
  input  logic       rx_en_i,
  output logic [7:0] strm_code_o,
  output logic       strm_valid_o,
  output logic       strm_bit_o,
  output logic       resume_o
);
  logic [1:0] ln_sync;
  logic       bit_tick;

  usb_rxfe_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line_i),
    .q_o   (ln_sync)
  );

  usb_rxfe_clkrec #(.FS_OSR(FS_OSR), .LS_OSR(LS_OSR)) u_clkrec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ln_i       (ln_sync),
    .low_speed_i(low_speed_i),
    .tick_o     (bit_tick)
  );

  usb_rxfe_bitseq #(.STUFF_RUN(STUFF_RUN), .RESUME_BITS(RESUME_BITS)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (bit_tick),
    .ln_i       (ln_sync),
    .low_speed_i(low_speed_i),
    .rx_en_i    (rx_en_i),
    .valid_o    (strm_valid_o),
    .code_o     (strm_code_o),
    .bit_o      (strm_bit_o),
    .resume_o   (resume_o)
  );
endmodule

// File: rtl/usb_rx_bit_frontend_chk.sv
module usb_rx_bit_frontend_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] line_i,
  input logic [1:0] ln_s,
  input logic       tick,
  input logic       strm_valid_o,
  input logic [7:0] strm_code_o,
  input logic       resume_o
);
  logic [1:0] cyc;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_sync_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc >= 2'd2) |-> (ln_s == $past(line_i, 2)));

  a_r3_one_sample_per_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick ##1 !tick);

  a_r4_code_defined: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strm_valid_o |-> (strm_code_o <= 8'h03));

  a_r8_stop_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strm_valid_o && strm_code_o == 8'h01) |=> !strm_valid_o);

  a_r9_resume_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);

  a_r9_resume_no_stream: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resume_o && strm_valid_o));
endmodule

bind usb_rx_bit_frontend usb_rx_bit_frontend_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_i      (line_i),
  .ln_s        (ln_sync),
  .tick        (bit_tick),
  .strm_valid_o(strm_valid_o),
  .strm_code_o (strm_code_o),
  .resume_o    (resume_o)
);

// File: tb/usb_rx_bit_frontend_test.sv
`timescale 1ns/1ps
module usb_rx_bit_frontend_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] line_i = 2'b00;
  logic       low_speed_i = 1'b0;
  logic       rx_en_i = 1'b1;
  logic [7:0] strm_code_o;
  logic       strm_valid_o, strm_bit_o, resume_o;

  always #10 clk = ~clk;

  usb_rx_bit_frontend uut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line_i), .low_speed_i(low_speed_i),
    .rx_en_i(rx_en_i), .strm_code_o(strm_code_o), .strm_valid_o(strm_valid_o),
    .strm_bit_o(strm_bit_o), .resume_o(resume_o)
  );

  // {jitter, low_speed, payload (sent LSB first after sync)}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 1'b0, 16'hA5C3}, {1'b0, 1'b0, 16'h00FF},
    {1'b0, 1'b1, 16'hFFFF}, {1'b1, 1'b0, 16'h0000},
    {1'b0, 1'b1, 16'h1234}, {1'b1, 1'b0, 16'hFE7F},
    {1'b0, 1'b0, 16'h8001}, {1'b1, 1'b1, 16'h5A5A}
  };

  int checks = 0, fails = 0;
  int raw [128]; int rn;
  int exp_c [160]; int exp_b [160]; int en;
  int ev_c [160]; int ev_b [160]; int ev_n = 0;
  int res_n = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rst_ni && strm_valid_o && ev_n < 160) begin
      ev_c[ev_n] = int'(strm_code_o);
      ev_b[ev_n] = int'(strm_bit_o);
      ev_n++;
    end
    if (rst_ni && resume_o) res_n++;
  end

  function automatic logic [1:0] j_of(input logic ls);
    return ls ? 2'b01 : 2'b10;
  endfunction

  task automatic hold(input logic [1:0] lvl, input int cyc);
    line_i = lvl;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push_raw(input int b, inout int ones, input bit stuff);
    raw[rn++] = b;
    ones = b ? ones + 1 : 0;
    if (stuff && ones == 6) begin
      raw[rn++] = 0;
      ones = 0;
    end
  endtask

  task automatic build_expect();
    int ones = 0;
    en = 0;
    exp_c[en] = 0; exp_b[en] = 0; en++;
    for (int i = 0; i < rn; i++) begin
      if (ones == 6) begin
        ones = 0;
        if (raw[i] == 1) begin exp_c[en] = 3; exp_b[en] = 0; en++; end
      end else begin
        exp_c[en] = 2; exp_b[en] = raw[i]; en++;
        ones = raw[i] ? ones + 1 : 0;
      end
    end
    exp_c[en] = 1; exp_b[en] = 0; en++;
  endtask

  task automatic send_raw(input logic ls, input bit jit);
    int osr = ls ? 32 : 4;
    logic [1:0] lvl = j_of(ls);
    for (int i = 0; i < rn; i++) begin
      if (raw[i] == 0) lvl = lvl ^ 2'b11;
      hold(lvl, jit ? osr + ((i % 2) ? 1 : -1) : osr);
    end
    hold(2'b00, 2 * osr);
    hold(j_of(ls), 4 * osr);
  endtask

  task automatic compare(input string req);
    bit ok = (ev_n == en);
    int bad = -1;
    for (int i = 0; i < en && i < ev_n; i++)
      if (bad < 0 && (ev_c[i] != exp_c[i] || (exp_c[i] == 2 && ev_b[i] != exp_b[i]))) bad = i;
    if (bad >= 0) begin
      ok = 1'b0;
      check(ok, req, ev_c[bad] * 10 + ev_b[bad], exp_c[bad] * 10 + exp_b[bad]);
    end else check(ok, req, ev_n, en);
  endtask

  task automatic go_idle(input logic ls);
    low_speed_i = ls;
    hold(j_of(ls), 6 * (ls ? 32 : 4));
    ev_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(strm_valid_o == 1'b0 && resume_o == 1'b0, "reset",
          int'(strm_valid_o) + 2 * int'(resume_o), 0);
    rst_ni = 1'b1;

    // R1: latency from K on the input to the start code, full speed
    go_idle(1'b0);
    begin
      int k = 0;
      line_i = 2'b01;
      while (!strm_valid_o && k < 20) begin @(negedge clk); k++; end
      check(k == 5 && strm_code_o == 8'h00, "R1 start latency", k, 5);
      hold(2'b01, 4); hold(2'b00, 8); hold(2'b10, 16);
    end

    // R2 R3 R4 R5 R6 R8: table of packets at both speeds, some with bit jitter
    foreach (VEC[v]) begin
      logic jit = VEC[v][17];
      logic ls  = VEC[v][16];
      int ones = 0;
      go_idle(ls);
      rn = 0;
      for (int i = 0; i < 8; i++) push_raw((i == 7) ? 1 : 0, ones, 1'b1);
      for (int i = 0; i < 16; i++) push_raw(int'(VEC[v][i]), ones, 1'b1);
      build_expect();
      send_raw(ls, jit);
      compare($sformatf("R2 R3 R4 R5 R6 R8 vector %0d", v));
    end

    // R7: seven 1s in a row without stuffing
    begin
      int ones = 0;
      go_idle(1'b0);
      rn = 0;
      for (int i = 0; i < 8; i++) push_raw((i == 7) ? 1 : 0, ones, 1'b0);
      for (int i = 0; i < 6; i++) push_raw(1, ones, 1'b0);
      push_raw(0, ones, 1'b0); push_raw(0, ones, 1'b0);
      build_expect();
      send_raw(1'b0, 1'b0);
      compare("R7 stuff error stream");
      check(ev_n > 14 && ev_c[14] == 3, "R7 error code position", ev_n > 14 ? ev_c[14] : -1, 3);
    end

    // R6: stuffed zero removed (counts data bits only)
    begin
      int ones = 0, nbits = 0;
      go_idle(1'b1);
      rn = 0;
      for (int i = 0; i < 8; i++) push_raw((i == 7) ? 1 : 0, ones, 1'b1);
      for (int i = 0; i < 8; i++) push_raw(1, ones, 1'b1);
      send_raw(1'b1, 1'b0);
      for (int i = 0; i < ev_n; i++) if (ev_c[i] == 2) nbits++;
      check(nbits == 16, "R6 stuffed bits dropped", nbits, 16);
    end

    // R9: resume boundary, full and low speed
    rx_en_i = 1'b0;
    go_idle(1'b0); res_n = 0;
    hold(2'b01, 29 * 4); hold(2'b10, 8 * 4);
    check(res_n == 0, "R9 K of 29 bits", res_n, 0);
    hold(2'b01, 30 * 4); hold(2'b10, 8 * 4);
    check(res_n == 1, "R9 K of 30 bits", res_n, 1);
    check(ev_n == 0, "R9 no stream while resume", ev_n, 0);
    hold(2'b01, 60 * 4); hold(2'b10, 8 * 4);
    check(res_n == 2, "R9 long K single pulse", res_n, 2);
    go_idle(1'b1); res_n = 0;
    hold(2'b10, 30 * 32); hold(2'b01, 4 * 32);
    check(res_n == 1, "R9 R2 low speed resume", res_n, 1);
    rx_en_i = 1'b1;

    // R4: after resume handling, packets start again with rx enabled
    go_idle(1'b0);
    hold(2'b01, 4);
    hold(2'b01, 8);
    check(ev_n >= 2 && ev_c[0] == 0 && ev_c[1] == 2 && ev_b[1] == 0, "R4 start then bit 0",
          ev_n >= 1 ? ev_c[0] : -1, 0);
    hold(2'b00, 8); hold(2'b10, 16);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule